// File: doc/BRIEF.md
# Shared-Bus EPROM Read Sequencer

This block sits on the host side of a bank of byte-wide EPROMs that share one data bus. Every device has its own active-low select line and all of them share one active-low read strobe. A host issues a read by raising a request with a flat word address. The upper address bits pick the device. The lower bits go to every device in parallel.

The sequencer first asserts the chosen select line. After a programmable number of cycles it lowers the common read strobe. A fixed number of cycles after the select went low, it captures the bus into a holding register and raises a one-cycle valid pulse. At the same time it releases both the select and the strobe. It then stays busy for a recovery gap, so that the device that just drove the bus has reached high impedance before another device can be enabled. Devices that are not addressed stay deselected and so remain in their low-power standby state.

All timing is given as whole clock cycles. Each count is the ceiling of the matching device time divided by the clock period: select-to-data, strobe-to-data and release-to-float.

Top module: `eprom_rd_ctrl`

## Requirements
- R1: While reset is high and in the first cycle after it, all select lines and the strobe are high (inactive), `rd_valid` is 0 and `busy` is 0.
- R2: When `rd_req` is high at a clock edge where `busy` was 0, the request is accepted. From the next cycle `busy` is 1, the select line whose index equals `rd_addr[21:19]` is low, and `mem_addr` equals `rd_addr[18:0]`.
- R3: At most one select line is low in any cycle.
- R4: The strobe `mem_oe_n` is low only while a select line is low. It falls `ACC_CYC-OE_CYC` cycles after the select falls and stays low for `OE_CYC` cycles.
- R5: `rd_valid` is high for exactly one cycle, `ACC_CYC` cycles after the acceptance edge. `rd_data` then holds the byte that the selected device drove while the strobe was low.
- R6: In the cycle where `rd_valid` is high, every select line and the strobe are already high.
- R7: After the `rd_valid` cycle, `busy` stays 1 for `DF_CYC` more cycles with all select lines high. It then returns to 0.
- R8: `mem_addr` and the select lines do not change while a select line is low.
- R9: `rd_data` keeps its value between `rd_valid` pulses.
- R10: A request made while `busy` is 1 is ignored. It produces no extra valid pulse, and `mem_addr` keeps the address of the access in flight.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_req | input | 1 | Read request, sampled while not busy |
| rd_addr | input | 22 | Word address: bits [21:19] pick the device, bits [18:0] pick the byte |
| busy | output | 1 | An access or its recovery gap is in progress |
| rd_valid | output | 1 | One-cycle pulse when `rd_data` is new |
| rd_data | output | 8 | Captured byte |
| mem_addr | output | 19 | Address shared by all devices |
| mem_ce_n | output | 8 | Per-device active-low select |
| mem_oe_n | output | 1 | Common active-low read strobe |
| mem_dq | input | 8 | Shared device data bus |

## Verification
The assertions assume that the bus carries a device byte only while that device's select and the shared strobe are both low. They also assume that requests can arrive in any cycle, including during an access or the recovery gap. The stimulus models each device as a pure function of its index and the shared address, and drives a distinct filler value whenever no device is enabled. It raises the request about three cycles in four at pseudo-random points. Addresses mix pseudo-random values with the first and last device and the extreme byte offsets.

// File: rtl/eprom_rd_pkg.sv
package eprom_rd_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_SETUP,
        PH_STROBE,
        PH_SAMPLE,
        PH_RECOVER
    } rd_phase_e;

    typedef struct packed {
        logic accept;
        logic sel_en;
        logic strobe;
        logic capture;
        logic busy;
    } rd_ctrl_t;

    function automatic int unsigned max3(int unsigned a, int unsigned b, int unsigned c);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

    function automatic int unsigned cnt_width(int unsigned n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/eprom_phase_timer.sv
module eprom_phase_timer #(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             done
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign done = (cnt_q == '0);

    // R4
    timer_reload_chk: assert property (@(posedge clk) disable iff (rst)
        load |=> cnt_q == $past(load_val));
endmodule

// File: rtl/eprom_rd_seq.sv
module eprom_rd_seq
    import eprom_rd_pkg::*;
#(
    parameter int SETUP_CYC  = 3,
    parameter int STROBE_CYC = 3,
    parameter int GAP_CYC    = 3,
    parameter int CNT_W      = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req,
    input  logic             tmr_done,
    output logic             tmr_load,
    output logic [CNT_W-1:0] tmr_val,
    output rd_ctrl_t         ctrl
);
    localparam logic [CNT_W-1:0] SETUP_LD  = (SETUP_CYC > 0) ? CNT_W'(SETUP_CYC - 1) : '0;
    localparam logic [CNT_W-1:0] STROBE_LD = CNT_W'(STROBE_CYC - 1);
    localparam logic [CNT_W-1:0] GAP_LD    = CNT_W'(GAP_CYC - 1);

    rd_phase_e phase_q, phase_d;

    always_comb begin
        phase_d  = phase_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        case (phase_q)
            PH_IDLE: if (req) begin
                tmr_load = 1'b1;
                if (SETUP_CYC > 0) begin
                    phase_d = PH_SETUP;
                    tmr_val = SETUP_LD;
                end else begin
                    phase_d = PH_STROBE;
                    tmr_val = STROBE_LD;
                end
            end
            PH_SETUP: if (tmr_done) begin
                phase_d  = PH_STROBE;
                tmr_load = 1'b1;
                tmr_val  = STROBE_LD;
            end
            PH_STROBE: if (tmr_done) phase_d = PH_SAMPLE;
            PH_SAMPLE: begin
                phase_d  = PH_RECOVER;
                tmr_load = 1'b1;
                tmr_val  = GAP_LD;
            end
            PH_RECOVER: if (tmr_done) phase_d = PH_IDLE;
            default: phase_d = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) phase_q <= PH_IDLE;
        else     phase_q <= phase_d;
    end

    always_comb begin
        ctrl.accept  = (phase_q == PH_IDLE) && req;
        ctrl.sel_en  = (phase_d == PH_SETUP) || (phase_d == PH_STROBE);
        ctrl.strobe  = (phase_d == PH_STROBE);
        ctrl.capture = (phase_d == PH_SAMPLE);
        ctrl.busy    = (phase_d != PH_IDLE);
    end

    // R2
    accept_leaves_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_IDLE && req) |=> phase_q != PH_IDLE);

    // R7
    sample_to_recover_chk: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_SAMPLE) |=> phase_q == PH_RECOVER);
endmodule

// File: rtl/eprom_cs_decode.sv
module eprom_cs_decode #(
    parameter int SEL_W   = 3,
    parameter int NUM_DEV = 8
) (
    input  logic [SEL_W-1:0]   sel,
    input  logic               en,
    output logic [NUM_DEV-1:0] ce_n
);
    for (genvar i = 0; i < NUM_DEV; i++) begin : g_dev
        assign ce_n[i] = !(en && (sel == SEL_W'(i)));
    end
endmodule

// File: rtl/eprom_rd_ctrl.sv
module eprom_rd_ctrl
    import eprom_rd_pkg::*;
#(
    parameter int DEV_ADDR_W = 19,
    parameter int DEV_SEL_W  = 3,
    parameter int DATA_W     = 8,
    parameter int ACC_CYC    = 6,
    parameter int OE_CYC     = 3,
    parameter int DF_CYC     = 3
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              rd_req,
    input  logic [DEV_ADDR_W+DEV_SEL_W-1:0]   rd_addr,
    output logic                              busy,
    output logic                              rd_valid,
    output logic [DATA_W-1:0]                 rd_data,
    output logic [DEV_ADDR_W-1:0]             mem_addr,
    output logic [(1<<DEV_SEL_W)-1:0]         mem_ce_n,
    output logic                              mem_oe_n,
    input  logic [DATA_W-1:0]                 mem_dq
);
    localparam int NUM_DEV   = 1 << DEV_SEL_W;
    localparam int HOST_W    = DEV_ADDR_W + DEV_SEL_W;
    localparam int SETUP_CYC = ACC_CYC - OE_CYC;
    localparam int CNT_W     = cnt_width(max3(SETUP_CYC, OE_CYC, DF_CYC));

    rd_ctrl_t               ctrl;
    logic                   tmr_load, tmr_done;
    logic [CNT_W-1:0]       tmr_val;
    logic [HOST_W-1:0]      addr_q;
    logic [DEV_SEL_W-1:0]   sel_src;
    logic [NUM_DEV-1:0]     ce_n_d, ce_n_q;
    logic                   oe_n_q, valid_q, busy_q;
    logic [DATA_W-1:0]      data_q;

    eprom_rd_seq #(
        .SETUP_CYC (SETUP_CYC),
        .STROBE_CYC(OE_CYC),
        .GAP_CYC   (DF_CYC),
        .CNT_W     (CNT_W)
    ) i_seq (
        .clk     (clk),
        .rst     (rst),
        .req     (rd_req),
        .tmr_done(tmr_done),
        .tmr_load(tmr_load),
        .tmr_val (tmr_val),
        .ctrl    (ctrl)
    );

    eprom_phase_timer #(.CNT_W(CNT_W)) i_timer (
        .clk     (clk),
        .rst     (rst),
        .load    (tmr_load),
        .load_val(tmr_val),
        .done    (tmr_done)
    );

    assign sel_src = ctrl.accept ? rd_addr[HOST_W-1:DEV_ADDR_W] : addr_q[HOST_W-1:DEV_ADDR_W];

    eprom_cs_decode #(.SEL_W(DEV_SEL_W), .NUM_DEV(NUM_DEV)) i_dec (
        .sel (sel_src),
        .en  (ctrl.sel_en),
        .ce_n(ce_n_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q  <= '0;
            ce_n_q  <= '1;
            oe_n_q  <= 1'b1;
            valid_q <= 1'b0;
            busy_q  <= 1'b0;
            data_q  <= '0;
        end else begin
            if (ctrl.accept) addr_q <= rd_addr;
            ce_n_q  <= ce_n_d;
            oe_n_q  <= !ctrl.strobe;
            valid_q <= ctrl.capture;
            busy_q  <= ctrl.busy;
            if (ctrl.capture) data_q <= mem_dq;
        end
    end

    assign mem_addr = addr_q[DEV_ADDR_W-1:0];
    assign mem_ce_n = ce_n_q;
    assign mem_oe_n = oe_n_q;
    assign rd_valid = valid_q;
    assign rd_data  = data_q;
    assign busy     = busy_q;

    // R3
    one_select_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(~mem_ce_n));

    // R4
    strobe_needs_select_chk: assert property (@(posedge clk) disable iff (rst)
        !mem_oe_n |-> (mem_ce_n != '1));

    // R4
    strobe_fall_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(mem_oe_n) |-> $stable(mem_ce_n) && (mem_ce_n != '1));

    // R5
    valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        rd_valid |=> !rd_valid);

    // R6
    release_on_valid_chk: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> mem_oe_n && (mem_ce_n == '1));

    // R7
    gap_after_valid_chk: assert property (@(posedge clk) disable iff (rst)
        rd_valid |=> busy && (mem_ce_n == '1));

    // R8
    addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        ((mem_ce_n != '1) && $past(mem_ce_n != '1)) |-> $stable(mem_addr) && $stable(mem_ce_n));

    // R9
    data_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !rd_valid |-> $stable(rd_data));
endmodule

// File: tb/test_eprom_rd_ctrl.sv
module test_eprom_rd_ctrl;
    localparam int ACC = 6;
    localparam int OE  = 3;
    localparam int DF  = 3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rd_req = 1'b0;
    logic [21:0] rd_addr = '0;
    logic        busy, rd_valid;
    logic [7:0]  rd_data;
    logic [18:0] mem_addr;
    logic [7:0]  mem_ce_n;
    logic        mem_oe_n;
    logic [7:0]  mem_dq;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    eprom_rd_ctrl #(
        .DEV_ADDR_W(19), .DEV_SEL_W(3), .DATA_W(8),
        .ACC_CYC(ACC), .OE_CYC(OE), .DF_CYC(DF)
    ) i_eprom_rd_ctrl (
        .clk(clk), .rst(rst), .rd_req(rd_req), .rd_addr(rd_addr),
        .busy(busy), .rd_valid(rd_valid), .rd_data(rd_data),
        .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n),
        .mem_dq(mem_dq)
    );

    function automatic logic [7:0] dev_byte(int dev, logic [18:0] a);
        return a[7:0] ^ {a[15:11], a[18:16]} ^ 8'(dev * 37 + 1);
    endfunction

    always_comb begin
        mem_dq = 8'hA5;
        for (int i = 0; i < 8; i++)
            if (!mem_ce_n[i] && !mem_oe_n) mem_dq = dev_byte(i, mem_addr);
    end

    task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got hang expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        bit          act;
        bit          busy_prev;
        int          t0;
        int          d;
        logic [21:0] a_acc;
        logic [7:0]  exp_data;
        logic [7:0]  exp_ce;
        logic        exp_oe;
        logic        exp_valid;
        logic [31:0] lfsr;
        logic [21:0] corner [3];
        act = 0; busy_prev = 0; t0 = 0; a_acc = '0; exp_data = 8'h00;
        lfsr = 32'h1234_5678;
        corner[0] = 22'h3FFFFF;
        corner[1] = 22'h000000;
        corner[2] = 22'h080000;

        // R1: reset state
        repeat (3) begin
            @(negedge clk);
            chk("R1 ce", {24'h0, mem_ce_n}, 32'hFF);
            chk("R1 oe", {31'h0, mem_oe_n}, 32'h1);
            chk("R1 valid", {31'h0, rd_valid}, 32'h0);
            chk("R1 busy", {31'h0, busy}, 32'h0);
        end
        rst = 1'b0;
        @(negedge clk);
        chk("R1 after ce", {24'h0, mem_ce_n}, 32'hFF);
        chk("R1 after busy", {31'h0, busy}, 32'h0);

        for (int n = 0; n < 3000; n++) begin
            // stimulus for the next edge
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            rd_req  = lfsr[0] | lfsr[3];
            rd_addr = (n % 7 == 0) ? corner[n % 3] : lfsr[27:6];
            @(negedge clk);
            // reference model for the edge just passed
            if (rd_req && !busy_prev) begin
                act = 1; t0 = n; a_acc = rd_addr;
            end else if (rd_req && busy_prev) begin
                // R10: ignored request keeps address in flight
                chk("R10 addr held", {13'h0, mem_addr}, {13'h0, a_acc[18:0]});
            end
            exp_ce = 8'hFF; exp_oe = 1'b1; exp_valid = 1'b0;
            if (act) begin
                d = n - t0;
                if (d < ACC) begin
                    exp_ce = ~(8'h01 << a_acc[21:19]);
                    exp_oe = !(d >= ACC - OE);
                end else if (d == ACC) begin
                    exp_valid = 1'b1;
                    exp_data = dev_byte(int'(a_acc[21:19]), a_acc[18:0]);
                end else if (d == ACC + DF + 1) begin
                    act = 0;
                end
            end else begin
                d = -1;
            end
            if (d >= 0 && d < ACC) begin
                chk("R2 select", {24'h0, mem_ce_n}, {24'h0, exp_ce});
                chk("R8 addr", {13'h0, mem_addr}, {13'h0, a_acc[18:0]});
            end else if (d == ACC) begin
                chk("R6 release", {24'h0, mem_ce_n}, 32'hFF);
            end else begin
                chk("R7 gap select", {24'h0, mem_ce_n}, 32'hFF);
            end
            chk("R3 onehot", {31'h0, ($countones(~mem_ce_n) <= 1)}, 32'h1);
            chk("R4 strobe", {31'h0, mem_oe_n}, {31'h0, exp_oe});
            chk("R5 valid", {31'h0, rd_valid}, {31'h0, exp_valid});
            if (exp_valid) chk("R5 data", {24'h0, rd_data}, {24'h0, exp_data});
            else           chk("R9 data hold", {24'h0, rd_data}, {24'h0, exp_data});
            chk("R7 busy", {31'h0, busy}, {31'h0, act});
            busy_prev = act;
        end

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule